// File: doc/BRIEF.md
# Raster Line and Cycle Sequencer with Sprite Fetch Strobes

This block is the free-running timing core of a raster video generator. A horizontal counter steps through the bus cycles of one scan line, and a vertical counter steps through the lines of one frame. Both counters wrap at limits set by the selected video standard. Four standards are supported. Each has its own line count and its own number of cycles per line, and each places the per-line events at its own positions.

From the horizontal position the block decodes single-cycle strobes. Each of the sprites gets a fetch-start strobe and a fetch-end strobe. Other strobes mark the vertical-blank test and the vertical-blank action, the start of a character-row fetch, the sprite data counter step and the counter base step, the sprite fetch test, the sprite expansion test and the sprite display test. A sprite's fetch window may begin near the end of one line and close early in the next. Downstream fetch and pixel logic consume these strobes. The block has no datapath of its own.

The standard is taken from `model_sel` while `rst` is high and is held until the next reset.

Top module: `raster_seq`

## Requirements
- R1: While `rst` is high every strobe output is 0. In the first cycle after `rst` falls, `cycle_no` is 0 and `line_no` is the last line of the chosen standard, so the first wrap enters line 0.
- R2: Outside reset, `cycle_no` rises by one per clock up to cycles-per-line minus 1 and then returns to 0. `line_no` rises by one in the clock where `cycle_no` returns to 0.
- R3: When `cycle_no` wraps while `line_no` holds the last line, `line_no` becomes 0.
- R4: `model_sel` encodes the standard: 0 gives 262 lines of 64 cycles, 1 gives 263 lines of 65 cycles, 2 gives 312 lines of 63 cycles, and 3 gives 312 lines of 65 cycles. Standard 3 uses the schedule of standard 1.
- R5: The following strobes fire in every line for every standard, one clock wide: `vbl_check` at cycle 0, `vbl_act` at cycle 1, `bad_fetch` at cycle 11, `mc_step` at cycle 14 and `mcbase_step` at cycle 15.
- R6: Bit s of `spr_dma_on` fires at cycle (B + 2s) mod C, where C is the cycles per line and B is 54 for standard 2 and 55 otherwise. Bit 0 also fires at B + 1. Standard 1 therefore gives 55/56, 57, 59, 61, 63, 0, 2 and 4.
- R7: Bit s of `spr_dma_off` fires at cycle (B + 5 + 2s) mod C. Standard 2 therefore gives 59, 61, 0, 2, 4, 6, 8 and 10.
- R8: `dma_check` fires at B and B + 1. `exp_check` fires at cycle 55. `disp_check` fires at 57 for standards 0 and 2 and at 58 for standards 1 and 3.
- R9: A change of `model_sel` while `rst` is low has no effect on the counts or strobes until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the standard |
| model_sel | input | 2 | Video standard select, sampled during reset |
| line_no | output | 9 | Current line |
| cycle_no | output | 7 | Current cycle within the line |
| spr_dma_on | output | 8 | Per-sprite fetch-start strobes |
| spr_dma_off | output | 8 | Per-sprite fetch-end strobes |
| vbl_check | output | 1 | Vertical-blank test strobe |
| vbl_act | output | 1 | Vertical-blank action strobe |
| bad_fetch | output | 1 | Character-row fetch start strobe |
| mc_step | output | 1 | Sprite data counter step strobe |
| mcbase_step | output | 1 | Sprite counter base step strobe |
| dma_check | output | 1 | Sprite fetch test strobe |
| exp_check | output | 1 | Sprite expansion test strobe |
| disp_check | output | 1 | Sprite display test strobe |

## Verification
The bench builds the block with its default parameters: eight sprites, a fetch spacing of two cycles and an end lag of five cycles. These are the only values for which the fixed schedules in the requirements apply. Since the standard is an input, one build reaches all four standards. The run covers a full frame of each standard, so every line wrap, frame wrap and cross-line fetch window is exercised. A change of the select input midway through one frame exercises R9.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    localparam int LINE_W  = 9;
    localparam int CYC_W   = 7;
    localparam int MAX_SPR = 8;

    typedef enum logic [1:0] {
        MDL_NTSC_OLD = 2'd0,
        MDL_NTSC     = 2'd1,
        MDL_PAL      = 2'd2,
        MDL_PALN     = 2'd3
    } model_e;

    // Geometry and schedule anchors of one standard
    typedef struct packed {
        logic [LINE_W-1:0] lines;
        logic [CYC_W-1:0]  cpl;
        logic [CYC_W-1:0]  spr_base;
        logic [CYC_W-1:0]  disp_pos;
    } geom_t;

    typedef struct packed {
        logic vbl_check;
        logic vbl_act;
        logic bad_fetch;
        logic mc_step;
        logic mcbase_step;
        logic dma_check;
        logic exp_check;
        logic disp_check;
    } evt_t;

    localparam logic [CYC_W-1:0] POS_VBL_CHECK = CYC_W'(0);
    localparam logic [CYC_W-1:0] POS_VBL_ACT   = CYC_W'(1);
    localparam logic [CYC_W-1:0] POS_BAD_FETCH = CYC_W'(11);
    localparam logic [CYC_W-1:0] POS_MC        = CYC_W'(14);
    localparam logic [CYC_W-1:0] POS_MCBASE    = CYC_W'(15);
    localparam logic [CYC_W-1:0] POS_EXP       = CYC_W'(55);

    function automatic geom_t geom_of(input model_e m);
        geom_t g;
        case (m)
            MDL_NTSC_OLD: g = '{lines: LINE_W'(262), cpl: CYC_W'(64),
                                spr_base: CYC_W'(55), disp_pos: CYC_W'(57)};
            MDL_NTSC:     g = '{lines: LINE_W'(263), cpl: CYC_W'(65),
                                spr_base: CYC_W'(55), disp_pos: CYC_W'(58)};
            MDL_PAL:      g = '{lines: LINE_W'(312), cpl: CYC_W'(63),
                                spr_base: CYC_W'(54), disp_pos: CYC_W'(57)};
            default:      g = '{lines: LINE_W'(312), cpl: CYC_W'(65),
                                spr_base: CYC_W'(55), disp_pos: CYC_W'(58)};
        endcase
        return g;
    endfunction

    // (a + off) modulo m, valid while a + off < 2*m
    function automatic logic [CYC_W-1:0] wrap_add(input logic [CYC_W-1:0] a,
                                                  input logic [CYC_W:0]   off,
                                                  input logic [CYC_W-1:0] m);
        logic [CYC_W+1:0] s;
        s = {2'b00, a} + {1'b0, off};
        if (s >= {2'b00, m})
            s = s - {2'b00, m};
        return s[CYC_W-1:0];
    endfunction

endpackage

// File: rtl/rsq_timebase.sv
module rsq_timebase
    import rsq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  model_e              model_in,
    output model_e              model_q,
    output geom_t               geom,
    output logic [LINE_W-1:0]   line,
    output logic [CYC_W-1:0]    cyc
);

    geom_t geom_in;
    logic  last_cyc;
    logic  last_line;

    always_comb begin
        geom_in   = geom_of(model_in);
        geom      = geom_of(model_q);
        last_cyc  = (cyc == geom.cpl - CYC_W'(1));
        last_line = (line == geom.lines - LINE_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            model_q <= model_in;
            cyc     <= '0;
            line    <= geom_in.lines - LINE_W'(1);
        end else if (last_cyc) begin
            cyc  <= '0;
            line <= last_line ? '0 : line + LINE_W'(1);
        end else begin
            cyc <= cyc + CYC_W'(1);
        end
    end

endmodule

// File: rtl/rsq_sprite_slot.sv
module rsq_sprite_slot
    import rsq_pkg::*;
#(
    parameter int IDX    = 0,
    parameter int STRIDE = 2,
    parameter int LAG    = 5
)(
    input  logic             en,
    input  logic [CYC_W-1:0] cyc,
    input  geom_t            geom,
    output logic             dma_on,
    output logic             dma_off
);

    localparam logic [CYC_W:0] OFF_ON  = (CYC_W+1)'(IDX * STRIDE);
    localparam logic [CYC_W:0] OFF_OFF = (CYC_W+1)'(IDX * STRIDE + LAG);
    localparam logic [CYC_W:0] OFF_ONE = (CYC_W+1)'(1);

    logic [CYC_W-1:0] pos_on;
    logic [CYC_W-1:0] pos_off;
    logic             hit_extra;

    always_comb begin
        pos_on  = wrap_add(geom.spr_base, OFF_ON,  geom.cpl);
        pos_off = wrap_add(geom.spr_base, OFF_OFF, geom.cpl);
    end

    generate
        if (IDX == 0) begin : g_first
            // First slot holds the bus for a second cycle at the start
            assign hit_extra = (cyc == wrap_add(geom.spr_base, OFF_ONE, geom.cpl));
        end else begin : g_other
            assign hit_extra = 1'b0;
        end
    endgenerate

    assign dma_on  = en && ((cyc == pos_on) || hit_extra);
    assign dma_off = en && (cyc == pos_off);

endmodule

// File: rtl/rsq_event_decode.sv
module rsq_event_decode
    import rsq_pkg::*;
(
    input  logic             en,
    input  logic [CYC_W-1:0] cyc,
    input  geom_t            geom,
    output evt_t             evt
);

    logic [CYC_W-1:0] chk_second;

    always_comb begin
        chk_second      = wrap_add(geom.spr_base, (CYC_W+1)'(1), geom.cpl);
        evt.vbl_check   = en && (cyc == POS_VBL_CHECK);
        evt.vbl_act     = en && (cyc == POS_VBL_ACT);
        evt.bad_fetch   = en && (cyc == POS_BAD_FETCH);
        evt.mc_step     = en && (cyc == POS_MC);
        evt.mcbase_step = en && (cyc == POS_MCBASE);
        evt.dma_check   = en && ((cyc == geom.spr_base) || (cyc == chk_second));
        evt.exp_check   = en && (cyc == POS_EXP);
        evt.disp_check  = en && (cyc == geom.disp_pos);
    end

endmodule

// File: rtl/raster_seq.sv
module raster_seq
    import rsq_pkg::*;
#(
    parameter int NUM_SPR    = MAX_SPR,
    parameter int SPR_STRIDE = 2,
    parameter int END_LAG    = 5
)(
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          model_sel,
    output logic [LINE_W-1:0]   line_no,
    output logic [CYC_W-1:0]    cycle_no,
    output logic [NUM_SPR-1:0]  spr_dma_on,
    output logic [NUM_SPR-1:0]  spr_dma_off,
    output logic                vbl_check,
    output logic                vbl_act,
    output logic                bad_fetch,
    output logic                mc_step,
    output logic                mcbase_step,
    output logic                dma_check,
    output logic                exp_check,
    output logic                disp_check
);

    model_e model_q;
    geom_t  geom;
    evt_t   evt;
    logic   run_en;

    assign run_en = !rst;

    rsq_timebase u_tb (
        .clk      (clk),
        .rst      (rst),
        .model_in (model_e'(model_sel)),
        .model_q  (model_q),
        .geom     (geom),
        .line     (line_no),
        .cyc      (cycle_no)
    );

    generate
        for (genvar s = 0; s < NUM_SPR; s++) begin : g_slot
            rsq_sprite_slot #(
                .IDX    (s),
                .STRIDE (SPR_STRIDE),
                .LAG    (END_LAG)
            ) u_slot (
                .en      (run_en),
                .cyc     (cycle_no),
                .geom    (geom),
                .dma_on  (spr_dma_on[s]),
                .dma_off (spr_dma_off[s])
            );
        end
    endgenerate

    rsq_event_decode u_evt (
        .en   (run_en),
        .cyc  (cycle_no),
        .geom (geom),
        .evt  (evt)
    );

    assign vbl_check   = evt.vbl_check;
    assign vbl_act     = evt.vbl_act;
    assign bad_fetch   = evt.bad_fetch;
    assign mc_step     = evt.mc_step;
    assign mcbase_step = evt.mcbase_step;
    assign dma_check   = evt.dma_check;
    assign exp_check   = evt.exp_check;
    assign disp_check  = evt.disp_check;

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker
    import rsq_pkg::*;
#(
    parameter int NUM_SPR = MAX_SPR
)(
    input logic               clk,
    input logic               rst,
    input logic [1:0]         model_q,
    input logic [LINE_W-1:0]  line_no,
    input logic [CYC_W-1:0]   cycle_no,
    input logic [NUM_SPR-1:0] spr_dma_on,
    input logic [NUM_SPR-1:0] spr_dma_off,
    input logic               vbl_check,
    input logic               vbl_act,
    input logic               bad_fetch,
    input logic               mc_step,
    input logic               mcbase_step,
    input logic               dma_check,
    input logic               exp_check,
    input logic               disp_check
);

    geom_t g;
    logic  at_end;
    logic  at_last_line;
    logic  any_strobe;

    always_comb begin
        g            = geom_of(model_e'(model_q));
        at_end       = (cycle_no == g.cpl - CYC_W'(1));
        at_last_line = (line_no == g.lines - LINE_W'(1));
        any_strobe   = (|spr_dma_on) || (|spr_dma_off) || vbl_check || vbl_act ||
                       bad_fetch || mc_step || mcbase_step || dma_check ||
                       exp_check || disp_check;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |-> !any_strobe);

    p_reset_state_r1: assert property (@(posedge clk)
        $fell(rst) |-> (cycle_no == '0) && at_last_line);

    p_cycle_step_r2: assert property (@(posedge clk) disable iff (rst)
        !at_end |=> cycle_no == CYC_W'($past(cycle_no) + CYC_W'(1)));

    p_line_step_r2: assert property (@(posedge clk) disable iff (rst)
        (at_end && !at_last_line) |=>
            (cycle_no == '0) && (line_no == LINE_W'($past(line_no) + LINE_W'(1))));

    p_line_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (at_end && at_last_line) |=> (line_no == '0) && (cycle_no == '0));

    p_model_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(model_q));

    p_vbl_order_r5: assert property (@(posedge clk) disable iff (rst)
        vbl_check |=> vbl_act);

    p_mc_order_r5: assert property (@(posedge clk) disable iff (rst)
        mc_step |=> mcbase_step);

    p_bad_fetch_pos_r5: assert property (@(posedge clk) disable iff (rst)
        bad_fetch |-> cycle_no == CYC_W'(11));

    p_start_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(spr_dma_on));

    p_end_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(spr_dma_off));

    p_check_with_s0_r8: assert property (@(posedge clk) disable iff (rst)
        dma_check |-> spr_dma_on[0]);

    p_exp_in_check_r8: assert property (@(posedge clk) disable iff (rst)
        exp_check |-> dma_check);

endmodule

bind raster_seq rsq_checker #(.NUM_SPR(NUM_SPR)) i_rsq_checker (
    .clk         (clk),
    .rst         (rst),
    .model_q     (model_q),
    .line_no     (line_no),
    .cycle_no    (cycle_no),
    .spr_dma_on  (spr_dma_on),
    .spr_dma_off (spr_dma_off),
    .vbl_check   (vbl_check),
    .vbl_act     (vbl_act),
    .bad_fetch   (bad_fetch),
    .mc_step     (mc_step),
    .mcbase_step (mcbase_step),
    .dma_check   (dma_check),
    .exp_check   (exp_check),
    .disp_check  (disp_check)
);

// File: tb/test_raster_seq.sv
module test_raster_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] model_sel = 2'd0;
    logic [8:0] line_no;
    logic [6:0] cycle_no;
    logic [7:0] spr_dma_on, spr_dma_off;
    logic       vbl_check, vbl_act, bad_fetch, mc_step, mcbase_step;
    logic       dma_check, exp_check, disp_check;

    int total = 0;
    int bad   = 0;
    int wd    = 0;
    bit chk_en  = 0;
    bit changed = 0;
    bit done    = 0;

    int r_model = 0;
    int r_line  = 0;
    int r_cyc   = 0;

    // Schedules as stated in R6..R8, index = model code
    int st_tab [4][8] = '{'{55,57,59,61,63,1,3,5},  '{55,57,59,61,63,0,2,4},
                          '{54,56,58,60,62,1,3,5},  '{55,57,59,61,63,0,2,4}};
    int en_tab [4][8] = '{'{60,62,0,2,4,6,8,10},    '{60,62,64,1,3,5,7,9},
                          '{59,61,0,2,4,6,8,10},    '{60,62,64,1,3,5,7,9}};
    int extra_s0 [4] = '{56, 56, 55, 56};
    int disp_tab [4] = '{57, 58, 57, 58};

    always #4 clk = ~clk;

    raster_seq i_raster_seq (
        .clk(clk), .rst(rst), .model_sel(model_sel),
        .line_no(line_no), .cycle_no(cycle_no),
        .spr_dma_on(spr_dma_on), .spr_dma_off(spr_dma_off),
        .vbl_check(vbl_check), .vbl_act(vbl_act), .bad_fetch(bad_fetch),
        .mc_step(mc_step), .mcbase_step(mcbase_step), .dma_check(dma_check),
        .exp_check(exp_check), .disp_check(disp_check)
    );

    function automatic int lines_of(int m);
        case (m)
            0: return 262;
            1: return 263;
            default: return 312;
        endcase
    endfunction

    function automatic int cpl_of(int m);
        case (m)
            0: return 64;
            2: return 63;
            default: return 65;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (model %0d line %0d cycle %0d)",
                     req, act, exp, r_model, r_line, r_cyc);
        end
    endtask

    // Behavioural reference: advances on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            r_model <= int'(model_sel);
            r_cyc   <= 0;
            r_line  <= lines_of(int'(model_sel)) - 1;
        end else if (r_cyc == cpl_of(r_model) - 1) begin
            r_cyc  <= 0;
            r_line <= (r_line == lines_of(r_model) - 1) ? 0 : r_line + 1;
        end else begin
            r_cyc <= r_cyc + 1;
        end
    end

    // Compare away from the active edge
    always @(negedge clk) begin
        if (chk_en) begin
            int eon, eoff, c;
            string tg_c, tg_l;
            c = r_cyc;
            eon = 0; eoff = 0;
            for (int s = 0; s < 8; s++) begin
                if (c == st_tab[r_model][s]) eon  |= (1 << s);
                if (c == en_tab[r_model][s]) eoff |= (1 << s);
            end
            if (c == extra_s0[r_model]) eon |= 1;
            if (rst) begin
                // R1: all strobes quiet in reset
                check("R1", int'(spr_dma_on), 0);
                check("R1", int'(spr_dma_off), 0);
                check("R1", int'({vbl_check, vbl_act, bad_fetch, mc_step,
                                  mcbase_step, dma_check, exp_check, disp_check}), 0);
            end else begin
                tg_c = changed ? "R9" : ((c == cpl_of(r_model) - 1) ? "R4" : "R2");
                tg_l = changed ? "R9" : ((r_line == 0) ? "R3" : ((r_line == lines_of(r_model) - 1) ? "R1" : "R2"));
                check(tg_c, int'(cycle_no), c);
                check(tg_l, int'(line_no), r_line);
                check("R5", int'({vbl_check, vbl_act, bad_fetch, mc_step, mcbase_step}),
                      int'({c == 0, c == 1, c == 11, c == 14, c == 15}));
                check(changed ? "R9" : "R6", int'(spr_dma_on), eon);
                check("R7", int'(spr_dma_off), eoff);
                check("R8", int'({dma_check, exp_check, disp_check}),
                      int'({(c == st_tab[r_model][0]) || (c == extra_s0[r_model]),
                            c == 55, c == disp_tab[r_model]}));
            end
        end
    end

    task automatic do_reset(int m);
        @(posedge clk); #2;
        rst = 1'b1;
        model_sel = 2'(m);
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
    endtask

    initial begin
        @(posedge clk);
        chk_en = 1;
        for (int m = 0; m < 4; m++) begin
            int n;
            do_reset(m);
            n = lines_of(m) * cpl_of(m) + 150;
            for (int k = 0; k < n; k++) begin
                @(posedge clk); #2;
                if (m == 2 && k == n / 2) begin
                    model_sel = 2'd0;   // R9: ignored until next reset
                    changed = 1;
                end
            end
            changed = 0;
        end
        chk_en = 0;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 190000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 190000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule